// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Unit

This block holds two independent down-counters behind a simple word-addressed register bus. Each counter has a reload value (divisor), a control word and a live count that can be read at any time. The control word carries a two-bit operation code (load, hold, run) and a three-bit tick-source code that picks one of four tick-enable inputs. The counters advance only on the selected tick enable, so one fast clock serves several timing rates.

When a running counter is at zero and its tick arrives, it reloads from its divisor and sets its own status bit. Expiry is therefore periodic, with a period of divisor+1 ticks. A two-bit mask gates the status bits onto one level-sensitive interrupt line. Software clears status bits by writing ones to a write-one-to-clear acknowledge address that always reads back as zero.

Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The map, in word addresses, is: 0x0 timer-0 divisor, 0x1 timer-0 control, 0x2 timer-0 count (read only), 0x4 timer-1 divisor, 0x5 timer-1 control, 0x6 timer-1 count (read only), 0x8 mask, 0x9 acknowledge, 0xA raw status, 0xB masked status.

Top module: `dual_tick_timer`

## Requirements
- R1: A control write with bits [1:0] = 0 copies the divisor into the count and stops the counter. A value of 1 stops the counter and keeps the count. A value of 2 makes the counter run from the next clock edge on. A control write acts in the cycle it is made.
- R2: A control write with bits [1:0] = 3 is discarded as a whole. The stored control word, the mode and the count stay as they were.
- R3: Control bits [4:2] pick the tick source: code 4+k selects `tick_en[k]` for k = 0..3. Codes 0 to 3 select no source, and a counter in run mode with such a code does not advance.
- R4: Writing a divisor only stores the value (readable at its address). It does not change the count.
- R5: Reading a count address returns the live count of that timer.
- R6: A running counter at zero that sees its tick reloads from its divisor and sets its status bit: timer 0 sets bit 0 and timer 1 sets bit 1. Otherwise a selected tick decrements the count by one.
- R7: A write to the acknowledge address clears every raw status bit whose written bit [n] is 1. The acknowledge address always reads as zero.
- R8: Masked status (0xB) equals raw status AND mask (mask in bits [1:0] of 0x8). `irq_o` is high exactly when the masked status is non-zero, one edge after any write that changes it.
- R9: If a timer expires in the same cycle that its status bit is acknowledged, the bit ends up set.
- R10: While `rst_n` is low at a clock edge, both counters stop with count, divisor and control at zero, and raw status and mask clear, so `irq_o` is low.
- R11: Unmapped addresses read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| tick_en | input | 4 | Tick-enable inputs selectable as sources |
| irq_o | output | 1 | Level interrupt, any masked status bit set |

## Verification
On every cycle the assertions check that a timer expiry sets its status bit and reloads the divisor. They also check that an acknowledge clears a bit unless an expiry hits it in the same cycle, that an all-zero mask write drops the interrupt, and that reset clears status and mask. The bench scenarios cover the rest. These are the operation codes, including the discarded code 3, and the mapping of each tick-source code to its input, with codes below 4 frozen. They also cover that a divisor write alone leaves the count alone, the zero readback of the acknowledge and unmapped addresses, and the ordering of hold against a tick in the same cycle.

// File: rtl/dtmr_pkg.sv
// Shared types and register offsets for the dual countdown timer.
// Assumes a word-addressed bus with a 4-bit address.
package dtmr_pkg;

    // Operation code held in control bits [1:0]
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

    // Stored control word: source code above operation
    typedef struct packed {
        logic [2:0] src;
        tmr_op_e    op;
    } tmr_ctrl_t;

    localparam int CTRL_W     = 5;
    localparam int SRC_BASE   = 4;   // first code that names a tick input
    localparam int TMR_STRIDE = 4;   // word spacing of the two timer groups

    // Offsets inside a timer group
    localparam logic [3:0] OFS_DIV  = 4'h0;
    localparam logic [3:0] OFS_CTRL = 4'h1;
    localparam logic [3:0] OFS_CNT  = 4'h2;

    // Interrupt unit addresses
    localparam logic [3:0] ADR_MASK   = 4'h8;
    localparam logic [3:0] ADR_ACK    = 4'h9;
    localparam logic [3:0] ADR_RAW    = 4'hA;
    localparam logic [3:0] ADR_MASKED = 4'hB;

endpackage

// File: rtl/dtmr_counter.sv
// One down-counter with divisor, control word and tick-source selection.
// Assumes at most one of div_wr / ctrl_wr per cycle (single write port).
// A control write with operation code 3 is dropped whole.
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_TICK = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 div_wr,
    input  logic                 ctrl_wr,
    input  logic [CNT_W-1:0]     wdata,
    input  logic [NUM_TICK-1:0]  tick_en,
    output logic [CNT_W-1:0]     count_q,
    output logic [CNT_W-1:0]     div_q,
    output logic [CTRL_W-1:0]    ctrl_rd,
    output logic                 hit
);

    tmr_ctrl_t          ctrl_q;
    tmr_ctrl_t          ctrl_new;
    logic               ctrl_take;
    logic               tick_sel;
    logic               running;
    logic               at_zero;

    assign ctrl_new  = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    assign ctrl_take = ctrl_wr && (ctrl_new.op != OP_BAD);
    assign running   = (ctrl_q.op == OP_RUN);
    assign at_zero   = (count_q == '0);
    assign ctrl_rd   = ctrl_q;

    // Map source code to a tick input; codes below SRC_BASE select nothing
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_TICK; i++) begin
            if (ctrl_q.src == 3'(SRC_BASE + i))
                tick_sel = tick_en[i];
        end
    end

    // Expiry strobe: running, at zero, ticked, and no control write pending
    assign hit = running && tick_sel && at_zero && !ctrl_take;

    // Divisor storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_wr)
            div_q <= wdata;
    end

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_take)
            ctrl_q <= ctrl_new;
    end

    // Count: load on control write, else decrement or reload on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ctrl_take) begin
            if (ctrl_new.op == OP_LOAD)
                count_q <= div_q;
        end else if (running && tick_sel) begin
            if (at_zero)
                count_q <= div_q;
            else
                count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/dtmr_irq.sv
// Raw status, mask and acknowledge logic with one level interrupt.
// Assumes hit strobes last one cycle; a set beats a same-cycle acknowledge.
module dtmr_irq #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] hit,
    input  logic               mask_wr,
    input  logic               ack_wr,
    input  logic [NUM_TMR-1:0] wbits,
    output logic [NUM_TMR-1:0] raw_q,
    output logic [NUM_TMR-1:0] mask_q,
    output logic [NUM_TMR-1:0] masked,
    output logic               irq_o
);

    logic [NUM_TMR-1:0] clr_bits;

    assign clr_bits = ack_wr ? wbits : '0;

    // Raw status: clear acknowledged bits, then OR in new expiries
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~clr_bits) | hit;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= wbits;
    end

    // Masked status and interrupt level
    assign masked = raw_q & mask_q;
    assign irq_o  = |masked;

endmodule

// File: rtl/dtmr_regdec.sv
// Address decode for writes and read-data multiplexing.
// Assumes timer groups at multiples of TMR_STRIDE; unmapped reads give zero.
module dtmr_regdec
    import dtmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int NUM_TMR = 2
) (
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt,
    input  logic [NUM_TMR-1:0][DATA_W-1:0]  div,
    input  logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl,
    input  logic [NUM_TMR-1:0]              raw,
    input  logic [NUM_TMR-1:0]              mask,
    input  logic [NUM_TMR-1:0]              masked,
    output logic [NUM_TMR-1:0]              div_wr,
    output logic [NUM_TMR-1:0]              ctrl_wr,
    output logic                            mask_wr,
    output logic                            ack_wr,
    output logic [DATA_W-1:0]               rd_data
);

    // Per-timer write strobes
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_wdec
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(t * TMR_STRIDE);
        assign div_wr[t]  = wr_en && (wr_addr == BASE + ADDR_W'(OFS_DIV));
        assign ctrl_wr[t] = wr_en && (wr_addr == BASE + ADDR_W'(OFS_CTRL));
    end

    // Interrupt-unit write strobes
    assign mask_wr = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
    assign ack_wr  = wr_en && (wr_addr == ADDR_W'(ADR_ACK));

    // Read multiplexer; acknowledge and unmapped addresses return zero
    always_comb begin
        rd_data = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (rd_addr == ADDR_W'(t * TMR_STRIDE) + ADDR_W'(OFS_DIV))
                rd_data = div[t];
            if (rd_addr == ADDR_W'(t * TMR_STRIDE) + ADDR_W'(OFS_CTRL))
                rd_data = DATA_W'(ctrl[t]);
            if (rd_addr == ADDR_W'(t * TMR_STRIDE) + ADDR_W'(OFS_CNT))
                rd_data = cnt[t];
        end
        if (rd_addr == ADDR_W'(ADR_MASK))
            rd_data = DATA_W'(mask);
        if (rd_addr == ADDR_W'(ADR_RAW))
            rd_data = DATA_W'(raw);
        if (rd_addr == ADDR_W'(ADR_MASKED))
            rd_data = DATA_W'(masked);
    end

endmodule

// File: rtl/dual_tick_timer.sv
// Top: two countdown timers, register decode and interrupt unit.
// Assumes tick_en inputs are single-cycle enables synchronous to clk.
module dual_tick_timer
    import dtmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NUM_TICK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_TICK-1:0] tick_en,
    output logic                irq_o
);

    localparam int NUM_TMR = 2;

    logic [NUM_TMR-1:0][DATA_W-1:0] cnt_arr;
    logic [NUM_TMR-1:0][DATA_W-1:0] div_arr;
    logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_arr;
    logic [NUM_TMR-1:0]             div_wr;
    logic [NUM_TMR-1:0]             ctrl_wr;
    logic [NUM_TMR-1:0]             hit_vec;
    logic [NUM_TMR-1:0]             raw_q;
    logic [NUM_TMR-1:0]             mask_q;
    logic [NUM_TMR-1:0]             masked;
    logic                           mask_wr;
    logic                           ack_wr;

    // Address decode and read path
    dtmr_regdec #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NUM_TMR(NUM_TMR)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .cnt    (cnt_arr),
        .div    (div_arr),
        .ctrl   (ctrl_arr),
        .raw    (raw_q),
        .mask   (mask_q),
        .masked (masked),
        .div_wr (div_wr),
        .ctrl_wr(ctrl_wr),
        .mask_wr(mask_wr),
        .ack_wr (ack_wr),
        .rd_data(rd_data)
    );

    // The two timers
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        dtmr_counter #(
            .CNT_W   (DATA_W),
            .NUM_TICK(NUM_TICK)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_wr (div_wr[t]),
            .ctrl_wr(ctrl_wr[t]),
            .wdata  (wr_data),
            .tick_en(tick_en),
            .count_q(cnt_arr[t]),
            .div_q  (div_arr[t]),
            .ctrl_rd(ctrl_arr[t]),
            .hit    (hit_vec[t])
        );
    end

    // Status, mask and interrupt
    dtmr_irq #(
        .NUM_TMR(NUM_TMR)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_vec),
        .mask_wr(mask_wr),
        .ack_wr (ack_wr),
        .wbits  (wr_data[NUM_TMR-1:0]),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .masked (masked),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/dtmr_chk.sv
// Checker for dual_tick_timer, attached by bind. Observes expiry strobes,
// status, mask and the timer-0 count and divisor.
module dtmr_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [1:0]        wbits,
    input logic [1:0]        hit_vec,
    input logic [1:0]        raw_q,
    input logic [1:0]        mask_q,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] div0
);

    logic ack_now;
    assign ack_now = wr_en && (wr_addr == 4'h9);

    // R6
    hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |=> raw_q[0]);

    // R6
    hit_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |=> (cnt0 == $past(div0)));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_now && wbits[0] && !hit_vec[0]) |=> !raw_q[0]);

    // R9
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_now && wbits[1] && hit_vec[1]) |=> raw_q[1]);

    // R8
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'h8 && wbits == 2'b00) |=> !irq_o);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (raw_q == 2'b00 && mask_q == 2'b00 && !irq_o));

endmodule

bind dual_tick_timer dtmr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wbits  (wr_data[1:0]),
    .hit_vec(hit_vec),
    .raw_q  (raw_q),
    .mask_q (mask_q),
    .cnt0   (cnt_arr[0]),
    .div0   (div_arr[0])
);

// File: tb/tb_dual_tick_timer.sv
`timescale 1ns/100ps
module tb_dual_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  tick_en = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_en(tick_en), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  tk;
        logic [3:0]  ra;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h0, 32'd3,    4'h0, 4'h2, 32'd0,    1'b0}, // 0  R4 divisor alone
        '{1'b1, 4'h1, 32'h10,   4'h0, 4'h2, 32'd3,    1'b0}, // 1  R1 load
        '{1'b1, 4'h1, 32'h12,   4'h0, 4'h2, 32'd3,    1'b0}, // 2  R1 run, no tick
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'h2, 32'd2,    1'b0}, // 3  R5 decrement
        '{1'b0, 4'h0, 32'd0,    4'h2, 4'h2, 32'd2,    1'b0}, // 4  R3 other tick
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'h2, 32'd1,    1'b0}, // 5
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'h2, 32'd0,    1'b0}, // 6
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'hA, 32'd1,    1'b0}, // 7  R6 status bit 0
        '{1'b0, 4'h0, 32'd0,    4'h0, 4'h2, 32'd3,    1'b0}, // 8  R6 reload
        '{1'b1, 4'h8, 32'd1,    4'h0, 4'hB, 32'd1,    1'b1}, // 9  R8 mask on
        '{1'b1, 4'h1, 32'h11,   4'h1, 4'h2, 32'd3,    1'b1}, // 10 R1 hold
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'h2, 32'd3,    1'b1}, // 11 R1 held
        '{1'b1, 4'h1, 32'h13,   4'h1, 4'h1, 32'h11,   1'b1}, // 12 R2 code 3
        '{1'b0, 4'h0, 32'd0,    4'h1, 4'h2, 32'd3,    1'b1}, // 13 R2 still held
        '{1'b1, 4'h9, 32'd1,    4'h0, 4'hA, 32'd0,    1'b0}, // 14 R7 clear
        '{1'b0, 4'h0, 32'd0,    4'h0, 4'h9, 32'd0,    1'b0}, // 15 R7 reads zero
        '{1'b1, 4'hF, 32'hFFFF, 4'h0, 4'hF, 32'd0,    1'b0}, // 16 R11 unmapped
        '{1'b0, 4'h0, 32'd0,    4'h0, 4'h8, 32'd1,    1'b0}, // 17 R11 mask kept
        '{1'b1, 4'h4, 32'd1,    4'h0, 4'h6, 32'd0,    1'b0}, // 18 R4 timer 1
        '{1'b1, 4'h5, 32'h1C,   4'h0, 4'h6, 32'd1,    1'b0}, // 19 R1 load t1
        '{1'b1, 4'h5, 32'h1E,   4'h0, 4'h6, 32'd1,    1'b0}, // 20 run src 7
        '{1'b0, 4'h0, 32'd0,    4'h8, 4'h6, 32'd0,    1'b0}, // 21 R3 tick 3
        '{1'b0, 4'h0, 32'd0,    4'h8, 4'hA, 32'd2,    1'b0}, // 22 R6 status bit 1
        '{1'b1, 4'h8, 32'd3,    4'h0, 4'hB, 32'd2,    1'b1}, // 23 R8
        '{1'b1, 4'h5, 32'h02,   4'h0, 4'h6, 32'd1,    1'b1}, // 24 run src 0
        '{1'b0, 4'h0, 32'd0,    4'hF, 4'h6, 32'd1,    1'b1}, // 25 R3 frozen
        '{1'b1, 4'h5, 32'h1A,   4'h0, 4'h6, 32'd1,    1'b1}, // 26 run src 6
        '{1'b0, 4'h0, 32'd0,    4'h4, 4'h6, 32'd0,    1'b1}, // 27 R3 tick 2
        '{1'b1, 4'h9, 32'd2,    4'h0, 4'hA, 32'd0,    1'b0}  // 28 R7 bit 1
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, release after the rising edge
    task automatic cycle(input logic w, input logic [3:0] a, input logic [31:0] d,
                         input logic [3:0] tk);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; tick_en = tk;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_en = '0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 irq", {31'd0, irq_o}, 32'd0);
        rd_check("R10 raw", 4'hA, 32'd0);
        rd_check("R10 cnt0", 4'h2, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].wr, VECS[i].wa, VECS[i].wd, VECS[i].tk);
            rd_check($sformatf("vector %0d", i), VECS[i].ra, VECS[i].exp_rd);
            check($sformatf("vector %0d irq", i), {31'd0, irq_o}, {31'd0, VECS[i].exp_irq});
        end

        // R9: timer 0 with divisor 0 hits on every tick; acknowledge same cycle
        cycle(1'b1, 4'h0, 32'd0, 4'h0);
        cycle(1'b1, 4'h1, 32'h10, 4'h0);
        cycle(1'b1, 4'h1, 32'h12, 4'h0);
        cycle(1'b1, 4'h9, 32'd1, 4'h1);
        rd_check("R9 set wins", 4'hA, 32'd1);
        check("R9 irq", {31'd0, irq_o}, 32'd1);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 irq low", {31'd0, irq_o}, 32'd0);
        rd_check("R10 mask", 4'h8, 32'd0);
        rd_check("R10 raw clr", 4'hA, 32'd0);
        rd_check("R10 ctrl0", 4'h1, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, 4'h0, 32'd0, 4'hF);
        cycle(1'b0, 4'h0, 32'd0, 4'hF);
        rd_check("R10 stopped", 4'hA, 32'd0);
        rd_check("R10 cnt1", 4'h6, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule